// File: doc/BRIEF.md
# Debug-Aware Low-Power Clock Controller

This block steps a small device between four power modes: run, sleep, stop and standby. In each mode it drives two clock enables, one for the free-running core clock and one for the bus clock. It also drives a source select that picks either the clock that software configured or the always-available internal RC oscillator. On the way back to run it issues the side effects that each mode needs: a pulse that resets the clock configuration, a system-reset request, and a flag that records that the device resumed from standby.

A 32-bit control register holds three debug override bits, one per low-power mode. When set, a bit keeps clocks alive in that mode so that an attached debugger does not lose its connection. The same register holds the software clock-source choice and the standby-resume flag. The register accepts whole-word writes only. Power-on reset is the synchronous active-low `rst_n`. The system reset that this block requests acts on its own state only in the way the requirements describe. The actual clock muxes, oscillators and power switches sit outside the block.

Top module: `lpc_ctrl_top`

## Requirements
- R1: After power-on reset the mode is run (`pwr_mode`=00), all register fields read 0, both clock enables are 1, `clk_src_sel`=0 (RC oscillator), and `cfg_rst_pulse`, `sys_rst_req` and `pwr_down` are 0.
- R2: A register write takes effect only when `reg_wr_en` is high and all four bits of `reg_wr_be` are set; any other write leaves every field unchanged. The fields are: bit 0 sleep debug, bit 1 stop debug, bit 2 standby debug, bit 8 standby-resume flag (reads the flag; writing 1 clears it) and bit 16 software source select (1 = configured system clock). All other read bits are 0.
- R3: A request (`lp_req` with `lp_mode` 01=sleep, 10=stop, 11=standby) is accepted only in run and moves `pwr_mode` to that code on the next cycle. `lp_mode`=00, requests made outside run, and `wake` while in run are all ignored. `wake` in any low-power mode returns to run on the next cycle. In run both clocks are on and `clk_src_sel` equals bit 16.
- R4: In sleep with the sleep debug bit clear, the core clock is on, the bus clock is off and `clk_src_sel` equals bit 16.
- R5: In sleep with the sleep debug bit set, both clocks are on from the selected clock (`clk_src_sel` = bit 16). Leaving sleep keeps bit 16 and raises no pulse.
- R6: In stop with the stop debug bit clear, both clock enables are 0.
- R7: In stop with the stop debug bit set, both clock enables are 1 and `clk_src_sel`=0.
- R8: On every exit from stop, bit 16 is cleared and `cfg_rst_pulse` is high for exactly the first cycle back in run. The clear wins over a write in the same cycle.
- R9: In standby with the standby debug bit clear, both clock enables are 0 and `pwr_down`=1. `pwr_down` is 0 in every other case.
- R10: In standby with the standby debug bit set, both clock enables are 1, `clk_src_sel`=0 and `pwr_down`=0.
- R11: On every exit from standby, `sys_rst_req` is high for exactly the first cycle back in run, bit 16 is cleared, the resume flag is set and the debug bits keep their values.
- R12: The resume flag is cleared by a full write with bit 8 = 1. If the flag is set and cleared in the same cycle, the set wins. Only power-on reset clears it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| lp_req | input | 1 | Low-power entry request |
| lp_mode | input | 2 | Requested mode: 01 sleep, 10 stop, 11 standby |
| wake | input | 1 | Wakeup event |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_be | input | 4 | Byte enables; all four needed |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read view |
| pwr_mode | output | 2 | Current mode: 00 run, 01 sleep, 10 stop, 11 standby |
| core_clk_en | output | 1 | Core clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| clk_src_sel | output | 1 | 0 = RC oscillator, 1 = configured system clock |
| cfg_rst_pulse | output | 1 | One-cycle clock-configuration reset on stop exit |
| sys_rst_req | output | 1 | One-cycle system-reset request on standby exit |
| pwr_down | output | 1 | Digital domain flagged as powered down |

## Verification
The assertions check the following on every cycle. Both exit pulses occur only on the first run cycle after the matching mode. The controller never moves straight from one low-power mode to another. Clocks are never enabled while the domain is flagged as powered down. The source-select bit is zero after any configuration clear. The debug bits stay the same across cycles with no full write. The resume flag rises only on a standby exit. Only the bench's scenarios can show the rest: the exact per-mode clock and source values for each debug setting, that partial writes and ignored requests leave state unchanged, and that set beats clear on the resume flag.

// File: rtl/lpc_pkg.sv
// Shared types and field positions for the low-power clock controller.
// Assumes a 32-bit control register; positions below are the software view.
package lpc_pkg;
    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_SLEEP = 2'b01,
        PM_STOP  = 2'b10,
        PM_STBY  = 2'b11
    } pmode_e;

    localparam int unsigned REG_W        = 32;
    localparam int unsigned BE_W         = REG_W / 8;
    localparam int unsigned DBG_N        = 3;
    localparam int unsigned DBG_SLEEP_B  = 0;
    localparam int unsigned DBG_STOP_B   = 1;
    localparam int unsigned DBG_STBY_B   = 2;
    localparam int unsigned RESUME_B     = 8;
    localparam int unsigned FAST_SEL_B   = 16;

    // Source select encodings
    localparam logic SRC_RC   = 1'b0;
    localparam logic SRC_FAST = 1'b1;
endpackage

// File: rtl/lpc_regs.sv
// Control register: debug override bits, software clock-source choice and
// standby-resume flag. Accepts whole-word writes only. Assumes cfg_clear and
// resume_set come from the sequencer in the cycle before the return to run.
module lpc_regs
    import lpc_pkg::*;
#(
    parameter int unsigned W   = REG_W,
    parameter int unsigned BEW = W / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [BEW-1:0] wr_be,
    input  logic [W-1:0]   wr_data,
    input  logic           cfg_clear,
    input  logic           resume_set,
    output logic [DBG_N-1:0] dbg_q,
    output logic           fast_sel_q,
    output logic           resume_q,
    output logic [W-1:0]   rd_data
);
    logic wr_full;
    logic unused_wr_bits;

    // Full-word write qualifier
    assign wr_full = wr_en && (&wr_be);
    assign unused_wr_bits = ^wr_data;

    // Debug override bits: POR only, whole-word writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_q <= '0;
        end else if (wr_full) begin
            dbg_q <= wr_data[DBG_N-1:0];
        end
    end

    // Software source select: cleared on stop/standby exit, clear beats write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_sel_q <= 1'b0;
        end else if (cfg_clear) begin
            fast_sel_q <= 1'b0;
        end else if (wr_full) begin
            fast_sel_q <= wr_data[FAST_SEL_B];
        end
    end

    // Resume flag: set on standby exit, write-1-to-clear, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resume_q <= 1'b0;
        end else if (resume_set) begin
            resume_q <= 1'b1;
        end else if (wr_full && wr_data[RESUME_B]) begin
            resume_q <= 1'b0;
        end
    end

    // Read view assembly
    always_comb begin
        rd_data = '0;
        rd_data[DBG_N-1:0]  = dbg_q;
        rd_data[RESUME_B]   = resume_q;
        rd_data[FAST_SEL_B] = fast_sel_q;
    end

    // R2
    dbg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_full) |-> $stable(dbg_q));

    // R8
    cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_clear) |-> !fast_sel_q);

    // R12
    resume_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_q) |-> $past(resume_set));
endmodule

// File: rtl/lpc_fsm.sv
// Power-mode sequencer. Accepts entry only from run, leaves any low-power
// mode on wake, and registers the one-cycle exit pulses so that they line up
// with the first run cycle. Assumes lp_mode is stable while lp_req is high.
module lpc_fsm
    import lpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lp_req,
    input  logic [1:0] lp_mode,
    input  logic       wake,
    output pmode_e     mode_q,
    output logic       cfg_clear,
    output logic       resume_set,
    output logic       cfg_rst_q,
    output logic       sys_rst_q
);
    pmode_e mode_d;
    logic   leaving;

    // Exit decode and side-effect strobes for the register block
    assign leaving    = (mode_q != PM_RUN) && wake;
    assign resume_set = leaving && (mode_q == PM_STBY);
    assign cfg_clear  = leaving && ((mode_q == PM_STOP) || (mode_q == PM_STBY));

    // Next-mode selection
    always_comb begin
        mode_d = mode_q;
        if (mode_q == PM_RUN) begin
            if (lp_req && (lp_mode != 2'b00)) begin
                mode_d = pmode_e'(lp_mode);
            end
        end else if (wake) begin
            mode_d = PM_RUN;
        end
    end

    // Mode register and exit pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= PM_RUN;
            cfg_rst_q <= 1'b0;
            sys_rst_q <= 1'b0;
        end else begin
            mode_q    <= mode_d;
            cfg_rst_q <= leaving && (mode_q == PM_STOP);
            sys_rst_q <= resume_set;
        end
    end

    // R3
    no_lp_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) != PM_RUN && mode_q != PM_RUN) |-> (mode_q == $past(mode_q)));

    // R8
    cfg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rst_q |-> (mode_q == PM_RUN && $past(mode_q) == PM_STOP));

    // R11
    sys_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_q |-> (mode_q == PM_RUN && $past(mode_q) == PM_STBY));

    // R8
    cfg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rst_q |=> !cfg_rst_q);
endmodule

// File: rtl/lpc_gate.sv
// Clock gating and source decode. Purely combinational: maps the current
// mode and the matching debug override onto the enables, source select and
// power-down flag. Assumes the debug bits take effect immediately.
module lpc_gate
    import lpc_pkg::*;
(
    input  pmode_e           mode,
    input  logic [DBG_N-1:0] dbg,
    input  logic             fast_sel,
    output logic             core_en,
    output logic             bus_en,
    output logic             src_sel,
    output logic             pdown
);
    logic fast_src;

    assign fast_src = fast_sel ? SRC_FAST : SRC_RC;

    // Per-mode decode
    always_comb begin
        core_en = 1'b1;
        bus_en  = 1'b1;
        src_sel = fast_src;
        pdown   = 1'b0;
        unique case (mode)
            PM_RUN: begin
                core_en = 1'b1;
            end
            PM_SLEEP: begin
                bus_en = dbg[DBG_SLEEP_B];
            end
            PM_STOP: begin
                src_sel = SRC_RC;
                core_en = dbg[DBG_STOP_B];
                bus_en  = dbg[DBG_STOP_B];
            end
            PM_STBY: begin
                src_sel = SRC_RC;
                core_en = dbg[DBG_STBY_B];
                bus_en  = dbg[DBG_STBY_B];
                pdown   = !dbg[DBG_STBY_B];
            end
            default: begin
                core_en = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/lpc_ctrl_top.sv
// Debug-aware low-power clock controller top. Wires the sequencer, the
// control register and the gating decode. Assumes rst_n is power-on reset.
module lpc_ctrl_top
    import lpc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lp_req,
    input  logic [1:0]         lp_mode,
    input  logic               wake,
    input  logic               reg_wr_en,
    input  logic [BE_W-1:0]    reg_wr_be,
    input  logic [REG_W-1:0]   reg_wr_data,
    output logic [REG_W-1:0]   reg_rd_data,
    output logic [1:0]         pwr_mode,
    output logic               core_clk_en,
    output logic               bus_clk_en,
    output logic               clk_src_sel,
    output logic               cfg_rst_pulse,
    output logic               sys_rst_req,
    output logic               pwr_down
);
    pmode_e           mode_q;
    logic             cfg_clear;
    logic             resume_set;
    logic [DBG_N-1:0] dbg_q;
    logic             fast_sel_q;
    logic             resume_q;

    lpc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .lp_req     (lp_req),
        .lp_mode    (lp_mode),
        .wake       (wake),
        .mode_q     (mode_q),
        .cfg_clear  (cfg_clear),
        .resume_set (resume_set),
        .cfg_rst_q  (cfg_rst_pulse),
        .sys_rst_q  (sys_rst_req)
    );

    lpc_regs #(.W(REG_W), .BEW(BE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_be      (reg_wr_be),
        .wr_data    (reg_wr_data),
        .cfg_clear  (cfg_clear),
        .resume_set (resume_set),
        .dbg_q      (dbg_q),
        .fast_sel_q (fast_sel_q),
        .resume_q   (resume_q),
        .rd_data    (reg_rd_data)
    );

    lpc_gate u_gate (
        .mode     (mode_q),
        .dbg      (dbg_q),
        .fast_sel (fast_sel_q),
        .core_en  (core_clk_en),
        .bus_en   (bus_clk_en),
        .src_sel  (clk_src_sel),
        .pdown    (pwr_down)
    );

    assign pwr_mode = mode_q;

    // R9
    pdown_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (!core_clk_en && !bus_clk_en));

    // R11
    stby_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> (resume_q && !fast_sel_q));

    // R7
    stop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_STOP) |-> (clk_src_sel == SRC_RC));
endmodule

// File: tb/lpc_ctrl_top_tb.sv
module lpc_ctrl_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lp_req = 1'b0;
    logic [1:0]  lp_mode = 2'b00;
    logic        wake = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_wr_be = 4'h0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic [1:0]  pwr_mode;
    logic        core_clk_en, bus_clk_en, clk_src_sel;
    logic        cfg_rst_pulse, sys_rst_req, pwr_down;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    logic [1:0] m_mode;
    logic [2:0] m_dbg;
    logic       m_fast, m_flag, m_cfgp, m_sysp;

    always #2.5 clk = ~clk;

    lpc_ctrl_top dut_i (
        .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .lp_mode(lp_mode),
        .wake(wake), .reg_wr_en(reg_wr_en), .reg_wr_be(reg_wr_be),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .pwr_mode(pwr_mode), .core_clk_en(core_clk_en),
        .bus_clk_en(bus_clk_en), .clk_src_sel(clk_src_sel),
        .cfg_rst_pulse(cfg_rst_pulse), .sys_rst_req(sys_rst_req),
        .pwr_down(pwr_down)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // expected {core, bus, src, pdown} per mode
    function automatic logic [3:0] exp_gate(input logic [1:0] md, input logic [2:0] dbg,
                                            input logic fast);
        case (md)
            2'b01:   return {1'b1, dbg[0], fast, 1'b0};
            2'b10:   return {dbg[1], dbg[1], 1'b0, 1'b0};
            2'b11:   return {dbg[2], dbg[2], 1'b0, !dbg[2]};
            default: return {1'b1, 1'b1, fast, 1'b0};
        endcase
    endfunction

    function automatic string gate_tag(input logic [1:0] md, input logic [2:0] dbg);
        case (md)
            2'b01:   return dbg[0] ? "R5" : "R4";
            2'b10:   return dbg[1] ? "R7" : "R6";
            2'b11:   return dbg[2] ? "R10" : "R9";
            default: return "R3";
        endcase
    endfunction

    task automatic model_step();
        logic full, leave;
        logic [1:0] old;
        full  = reg_wr_en && (reg_wr_be == 4'hF);
        old   = m_mode;
        leave = (old != 2'b00) && wake;
        if (old == 2'b00 && lp_req && lp_mode != 2'b00) m_mode = lp_mode;
        else if (leave) m_mode = 2'b00;
        m_cfgp = leave && old == 2'b10;
        m_sysp = leave && old == 2'b11;
        if (full) m_dbg = reg_wr_data[2:0];
        if (leave && old[1]) m_fast = 1'b0;
        else if (full) m_fast = reg_wr_data[16];
        if (m_sysp) m_flag = 1'b1;
        else if (full && reg_wr_data[8]) m_flag = 1'b0;
    endtask

    task automatic compare_all();
        logic [3:0] g;
        string t;
        g = exp_gate(m_mode, m_dbg, m_fast);
        t = gate_tag(m_mode, m_dbg);
        chk("R3", "pwr_mode", {30'b0, pwr_mode}, {30'b0, m_mode});
        chk(t, "gate", {28'b0, core_clk_en, bus_clk_en, clk_src_sel, pwr_down}, {28'b0, g});
        chk("R8", "cfg_rst_pulse", {31'b0, cfg_rst_pulse}, {31'b0, m_cfgp});
        chk("R11", "sys_rst_req", {31'b0, sys_rst_req}, {31'b0, m_sysp});
        chk("R2", "dbg bits", reg_rd_data & 32'hFFFE_FEFF, {29'b0, m_dbg});
        chk("R8", "fast bit", {31'b0, reg_rd_data[16]}, {31'b0, m_fast});
        chk("R12", "resume flag", {31'b0, reg_rd_data[8]}, {31'b0, m_flag});
    endtask

    // one clock: drive at negedge, model after edge, compare at next negedge
    task automatic cyc(input logic rq, input logic [1:0] md, input logic wk,
                       input logic we, input logic [3:0] be, input logic [31:0] d);
        lp_req = rq; lp_mode = md; wake = wk;
        reg_wr_en = we; reg_wr_be = be; reg_wr_data = d;
        @(posedge clk);
        #1 model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(); cyc(0, 2'b00, 0, 0, 4'h0, 32'h0); endtask
    task automatic wr(input logic [31:0] d); cyc(0, 2'b00, 0, 1, 4'hF, d); endtask
    task automatic enter(input logic [1:0] md); cyc(1, md, 0, 0, 4'h0, 32'h0); endtask
    task automatic wk(); cyc(0, 2'b00, 1, 0, 4'h0, 32'h0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        m_mode = 2'b00; m_dbg = 3'b0; m_fast = 0; m_flag = 0; m_cfgp = 0; m_sysp = 0;
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "reset outputs",
            {reg_rd_data[27:0], pwr_mode, core_clk_en, bus_clk_en},
            {28'h0, 2'b00, 1'b1, 1'b1});
        chk("R1", "reset side outputs",
            {29'b0, clk_src_sel, cfg_rst_pulse, sys_rst_req} | {31'b0, pwr_down},
            32'h0);
        // R2: partial write ignored
        cyc(0, 2'b00, 0, 1, 4'h7, 32'h0001_0107);
        wr(32'h0001_0000);                 // fast select
        // R3: wake in run, mode 00 ignored
        wk(); enter(2'b00);
        // R4 then R5 (sleep keeps source)
        enter(2'b01); idle(); wk();
        wr(32'h0001_0001); enter(2'b01);
        enter(2'b10);                      // R3: request outside run ignored
        wk();
        // R6 and R8
        wr(32'h0001_0000); enter(2'b10); idle();
        cyc(0, 2'b00, 1, 1, 4'hF, 32'h0001_0000); // clear beats write
        idle();
        // R7
        wr(32'h0001_0002); enter(2'b10); wk();
        // R9 and R11
        wr(32'h0001_0000); enter(2'b11); idle(); wk(); idle();
        // R12: clear, then set-wins on simultaneous exit
        wr(32'h0000_0100);
        wr(32'h0001_0004); enter(2'b11);
        cyc(0, 2'b00, 1, 1, 4'hF, 32'h0000_0104);  // R10 exit with clear write
        wr(32'h0000_0100); idle();
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic rq, wkk, we;
            logic [3:0] be;
            logic [31:0] d;
            rq  = ($urandom % 4) == 0;
            wkk = ($urandom % 5) == 0;
            we  = ($urandom % 8) == 0;
            be  = (($urandom % 2) == 0) ? 4'hF : 4'($urandom);
            d   = $urandom & 32'h0001_0107;
            cyc(rq, 2'($urandom), wkk, we, be, d);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule